// File: doc/BRIEF.md
# Compressed-Instruction Execution Core

This block executes one 16-bit compressed instruction in each clock cycle. It holds a 32-entry, 32-bit register file. It decodes the instruction on `inst` and performs the register update, the memory access or the change of program counter that the instruction calls for. The program counter and instruction fetch sit outside the block. The block only requests a new PC through an enable/value pair. When no request is made, the external logic steps the PC by 2.

Data memory is one word wide and answers reads within the same cycle. The core drives address, write data and one enable for each direction, and takes the read word from `mem_dout` in that cycle. Every register write is also shown on dedicated writeback outputs in the cycle it is committed. The register file takes the new value at the next rising edge. Stack-relative instructions use x2 as an implicit base. The short-form instructions reach only x8 to x15 through 3-bit register fields (x8 + field).

Reset is synchronous and active low. While `rst_n` is low, every enable output is held low, and each clock edge clears the register file.

Top module: `cxc_core`

## Requirements
- R1: While rst_n is low, mem_wen, mem_ren, control_en and wb_en are low. After reset every register reads as zero.
- R2: Register-register forms, with op[1:0]=10 and inst[15:12] = 1001 (add: rd=inst[11:7], rs2=inst[6:2], both nonzero), write x[rd]+x[rs2]. With inst[15:12] = 1000 and rs2 nonzero (move), they write x[rs2] to x[rd].
- R3: With op 01, funct3 inst[15:13] = 000 (add immediate), 010 (load immediate) and 011 (upper immediate, rd not 0 or 2), using imm = sext({inst[12],inst[6:2]}), the core writes x[rd]+imm, imm, and imm<<12 respectively.
- R4: Shift-left immediate (funct3 000, op 10, inst[12]=0, rd nonzero) writes x[rd] << inst[6:2]. When inst[12]=1 the instruction has no effect.
- R5: Stack store (funct3 110, op 10) writes x[inst[6:2]] to address x2 + {inst[8:7],inst[12:9],2'b00}. Stack-pointer add (funct3 000, op 00) writes x2 + {inst[10:7],inst[12:11],inst[5],inst[6],2'b00} to x(8+inst[4:2]). An all-zero offset field makes the stack-pointer add have no effect.
- R6: Word load (funct3 010, op 00) drives mem_ren and address x(8+inst[9:7]) + {inst[5],inst[12:10],inst[6],2'b00}, and writes mem_dout to x(8+inst[4:2]). Word store (funct3 110, op 00) drives mem_wen with x(8+inst[4:2]) on mem_din to the same form of address.
- R7: Branch-if-zero (funct3 110, op 01) tests x(8+inst[9:7]). When the register is zero it drives control_en and control_pc = current_pc + sext({inst[12],inst[6:5],inst[2],inst[11:10],inst[4:3],0}). Otherwise control_en stays low.
- R8: Jump (funct3 101, op 01) always drives control_en and control_pc = current_pc + sext({inst[12],inst[8],inst[10:9],inst[6],inst[7],inst[2],inst[11],inst[5:3],0}).
- R9: Register jump (inst[15:12]=1000, rs1=inst[11:7] nonzero, inst[6:2]=0, op 10) drives control_en with control_pc = x[rs1].
- R10: A nop (add immediate with rd=0), 16'h8000 and 16'h0000 produce no register write, no memory access and no PC request.
- R11: Writes aimed at x0 are dropped: load immediate with rd=0 has no effect, and wb_en is never high with wb_addr zero.
- R12: wb_en, wb_addr and wb_data report a write in the cycle it is committed, and the register holds the value from the next edge. mem_wen and mem_ren are never high together. While an enable is low, its address and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| inst | input | 16 | Compressed instruction to execute this cycle |
| mem_dout | input | 32 | Read word from data memory |
| current_pc | input | 32 | Address of the instruction on `inst` |
| mem_wen | output | 1 | Memory write strobe |
| mem_din | output | 32 | Word to store |
| mem_ren | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory word address |
| control_en | output | 1 | Request to load a new PC |
| control_pc | output | 32 | New PC value |
| wb_en | output | 1 | Register write this cycle |
| wb_addr | output | 5 | Destination register |
| wb_data | output | 32 | Value written |

## Verification
The assertions are checked on every cycle. They cover the following: enables stay quiet during reset, the two memory strobes never overlap, x0 is never reported as written, every load writes the memory word into x8 to x15, and a committed write appears at the register file's read port one cycle later. The bench's scenarios cover the arithmetic results, the immediate and offset bit scrambles, branch taken versus not taken, and the reserved or hint patterns that must do nothing. These are checked against a register model kept in the bench. The same scenarios show that a value written in one instruction is seen by the next.

// File: rtl/cxc_pkg.sv
// Shared widths, operation codes and the decoded-instruction record for
// the compressed execution core. Assumes a 32-register, 32-bit machine.
package cxc_pkg;
    localparam int XLEN      = 32;
    localparam int ILEN      = 16;
    localparam int NREG      = 32;
    localparam int RAW       = $clog2(NREG);
    localparam int SP_IDX    = 2;

    typedef enum logic [3:0] {
        OP_NONE, OP_ADD, OP_MV, OP_JR, OP_ADDI, OP_SLLI, OP_LI, OP_LUI,
        OP_SWSP, OP_ADDSP, OP_LW, OP_SW, OP_BEQZ, OP_J
    } cx_op_e;

    typedef struct packed {
        cx_op_e              op;
        logic [RAW-1:0]      rs1;
        logic [RAW-1:0]      rs2;
        logic [RAW-1:0]      rd;
        logic [XLEN-1:0]     imm;
    } cx_dec_t;
endpackage

// File: rtl/cxc_decode.sv
// Combinational decoder: turns one 16-bit compressed instruction into an
// operation code, register indices and an assembled immediate. Patterns
// outside the supported set, hints and reserved codes decode to OP_NONE.
module cxc_decode
    import cxc_pkg::*;
(
    input  logic [ILEN-1:0] inst,
    output cx_dec_t         dec
);
    logic [RAW-1:0] f_hi, f_lo, rp_hi, rp_lo;
    logic [XLEN-1:0] ci_sext;

    assign f_hi    = inst[11:7];
    assign f_lo    = inst[6:2];
    assign rp_hi   = {2'b01, inst[9:7]};
    assign rp_lo   = {2'b01, inst[4:2]};
    assign ci_sext = {{26{inst[12]}}, inst[12], inst[6:2]};

    // Select operation and operands from the quadrant and funct3 fields.
    always_comb begin
        dec     = '0;
        dec.op  = OP_NONE;
        case ({inst[15:13], inst[1:0]})
            5'b000_00: if (inst[12:5] != 8'd0) begin
                dec.op  = OP_ADDSP;
                dec.rs1 = RAW'(SP_IDX);
                dec.rd  = rp_lo;
                dec.imm = {22'd0, inst[10:7], inst[12:11], inst[5], inst[6], 2'b00};
            end
            5'b010_00: begin
                dec.op  = OP_LW;
                dec.rs1 = rp_hi;
                dec.rd  = rp_lo;
                dec.imm = {25'd0, inst[5], inst[12:10], inst[6], 2'b00};
            end
            5'b110_00: begin
                dec.op  = OP_SW;
                dec.rs1 = rp_hi;
                dec.rs2 = rp_lo;
                dec.imm = {25'd0, inst[5], inst[12:10], inst[6], 2'b00};
            end
            5'b000_01: if (f_hi != '0) begin
                dec.op  = OP_ADDI;
                dec.rs1 = f_hi;
                dec.rd  = f_hi;
                dec.imm = ci_sext;
            end
            5'b010_01: if (f_hi != '0) begin
                dec.op  = OP_LI;
                dec.rd  = f_hi;
                dec.imm = ci_sext;
            end
            5'b011_01: if (f_hi != '0 && f_hi != RAW'(SP_IDX)) begin
                dec.op  = OP_LUI;
                dec.rd  = f_hi;
                dec.imm = {{14{inst[12]}}, inst[12], inst[6:2], 12'd0};
            end
            5'b101_01: begin
                dec.op  = OP_J;
                dec.imm = {{21{inst[12]}}, inst[8], inst[10:9], inst[6], inst[7],
                           inst[2], inst[11], inst[5:3], 1'b0};
            end
            5'b110_01: begin
                dec.op  = OP_BEQZ;
                dec.rs1 = rp_hi;
                dec.imm = {{24{inst[12]}}, inst[6:5], inst[2], inst[11:10],
                           inst[4:3], 1'b0};
            end
            5'b000_10: if (f_hi != '0 && !inst[12]) begin
                dec.op  = OP_SLLI;
                dec.rs1 = f_hi;
                dec.rd  = f_hi;
                dec.imm = {27'd0, inst[6:2]};
            end
            5'b100_10: begin
                if (!inst[12]) begin
                    if (f_lo == '0 && f_hi != '0) begin
                        dec.op  = OP_JR;
                        dec.rs1 = f_hi;
                    end else if (f_lo != '0 && f_hi != '0) begin
                        dec.op  = OP_MV;
                        dec.rs2 = f_lo;
                        dec.rd  = f_hi;
                    end
                end else if (f_lo != '0 && f_hi != '0) begin
                    dec.op  = OP_ADD;
                    dec.rs1 = f_hi;
                    dec.rs2 = f_lo;
                    dec.rd  = f_hi;
                end
            end
            5'b110_10: begin
                dec.op  = OP_SWSP;
                dec.rs1 = RAW'(SP_IDX);
                dec.rs2 = f_lo;
                dec.imm = {24'd0, inst[8:7], inst[12:9], 2'b00};
            end
            default: dec.op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/cxc_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 is hard-wired to zero. Assumes a synchronous active-low reset
// that clears every entry.
module cxc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [N];

    // Clear on reset, otherwise commit the write to any nonzero entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n || i == 0)                 regs[i] <= '0;
            else if (we && waddr == AW'(i))       regs[i] <= wdata;
        end
    end

    // Read both ports without delay.
    always_comb begin
        rdata_a = regs[raddr_a];
        rdata_b = regs[raddr_b];
    end

    // R12
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we) && $past(waddr) != '0 && raddr_a == $past(waddr))
        |-> rdata_a == $past(wdata));
endmodule

// File: rtl/cxc_core.sv
// Single-cycle compressed-instruction core. Reads operands, computes one
// result and reports a register write, a memory access or a PC request in
// the same cycle. PC and fetch live outside; memory reads are combinational.
module cxc_core
    import cxc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      inst,
    input  logic [31:0]      mem_dout,
    input  logic [31:0]      current_pc,
    output logic             mem_wen,
    output logic [31:0]      mem_din,
    output logic             mem_ren,
    output logic [31:0]      mem_addr,
    output logic             control_en,
    output logic [31:0]      control_pc,
    output logic             wb_en,
    output logic [4:0]       wb_addr,
    output logic [31:0]      wb_data
);
    cx_dec_t         dec;
    logic [XLEN-1:0] ra, rb, sum_ai;
    logic            wb_v, st_v, ld_v, br_v;
    logic [XLEN-1:0] wb_d, m_a, m_d, pc_n;

    cxc_decode u_dec (.inst(inst), .dec(dec));

    cxc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(wb_en), .waddr(wb_addr), .wdata(wb_data),
        .raddr_a(dec.rs1), .raddr_b(dec.rs2),
        .rdata_a(ra), .rdata_b(rb)
    );

    assign sum_ai = ra + dec.imm;

    // Compute the effect of the decoded operation.
    always_comb begin
        wb_v = 1'b0; st_v = 1'b0; ld_v = 1'b0; br_v = 1'b0;
        wb_d = '0;   m_a  = '0;   m_d  = '0;   pc_n = '0;
        case (dec.op)
            OP_ADD:   begin wb_v = 1'b1; wb_d = ra + rb; end
            OP_MV:    begin wb_v = 1'b1; wb_d = rb; end
            OP_ADDI,
            OP_ADDSP: begin wb_v = 1'b1; wb_d = sum_ai; end
            OP_SLLI:  begin wb_v = 1'b1; wb_d = ra << dec.imm[4:0]; end
            OP_LI,
            OP_LUI:   begin wb_v = 1'b1; wb_d = dec.imm; end
            OP_LW:    begin wb_v = 1'b1; ld_v = 1'b1; m_a = sum_ai; wb_d = mem_dout; end
            OP_SW,
            OP_SWSP:  begin st_v = 1'b1; m_a = sum_ai; m_d = rb; end
            OP_BEQZ:  if (ra == '0) begin br_v = 1'b1; pc_n = current_pc + dec.imm; end
            OP_J:     begin br_v = 1'b1; pc_n = current_pc + dec.imm; end
            OP_JR:    begin br_v = 1'b1; pc_n = ra; end
            default:  ;
        endcase
    end

    // Hold every strobe low in reset and zero unused companions.
    always_comb begin
        wb_en      = rst_n & wb_v;
        wb_addr    = wb_en ? dec.rd : '0;
        wb_data    = wb_en ? wb_d : '0;
        mem_wen    = rst_n & st_v;
        mem_ren    = rst_n & ld_v;
        mem_addr   = (mem_wen | mem_ren) ? m_a : '0;
        mem_din    = mem_wen ? m_d : '0;
        control_en = rst_n & br_v;
        control_pc = control_en ? pc_n : '0;
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !(mem_wen || mem_ren || control_en || wb_en));
    // R12
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wen && mem_ren));
    // R11
    wb_x0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_addr != 5'd0);
    // R6
    load_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ren |-> (wb_en && wb_data == mem_dout && wb_addr >= 5'd8 && wb_addr <= 5'd15));
endmodule

// File: tb/tb_cxc_core.sv
module tb_cxc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] inst = 16'h0001;
    logic [31:0] mem_dout = '0, current_pc = '0;
    logic        mem_wen, mem_ren, control_en, wb_en;
    logic [31:0] mem_din, mem_addr, control_pc, wb_data;
    logic [4:0]  wb_addr;

    int n_run = 0, n_fail = 0;
    logic [31:0] m [32];
    logic        e_wen, e_ren, e_cen, e_wben;
    logic [31:0] e_addr, e_din, e_cpc, e_wbd, pc_v;
    logic [4:0]  e_wba;

    always #4 clk = ~clk;

    cxc_core dut (.*);

    function automatic logic [31:0] sx6(input logic [5:0] v);
        return {{26{v[5]}}, v};
    endfunction

    function automatic logic [15:0] enc_add(input logic [4:0] rd, rs2);
        return {4'b1001, rd, rs2, 2'b10};
    endfunction
    function automatic logic [15:0] enc_mv(input logic [4:0] rd, rs2);
        return {4'b1000, rd, rs2, 2'b10};
    endfunction
    function automatic logic [15:0] enc_jr(input logic [4:0] rs1);
        return {4'b1000, rs1, 5'd0, 2'b10};
    endfunction
    function automatic logic [15:0] enc_ci(input logic [2:0] f3, input logic [4:0] rd,
                                           input logic [5:0] im, input logic [1:0] q);
        return {f3, im[5], rd, im[4:0], q};
    endfunction
    function automatic logic [15:0] enc_swsp(input logic [4:0] rs2, input logic [7:2] o);
        return {3'b110, o[5:2], o[7:6], rs2, 2'b10};
    endfunction
    function automatic logic [15:0] enc_asp(input logic [2:0] rdp, input logic [9:2] z);
        return {3'b000, z[5:4], z[9:6], z[2], z[3], rdp, 2'b00};
    endfunction
    function automatic logic [15:0] enc_mem(input logic [2:0] f3, rs1p, input logic [6:2] o,
                                            input logic [2:0] rp);
        return {f3, o[5:3], rs1p, o[2], o[6], rp, 2'b00};
    endfunction
    function automatic logic [15:0] enc_beqz(input logic [2:0] rs1p, input logic [8:1] o);
        return {3'b110, o[8], o[4:3], rs1p, o[7:6], o[2:1], o[5], 2'b01};
    endfunction
    function automatic logic [15:0] enc_j(input logic [11:1] o);
        return {3'b101, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
    endfunction

    task automatic clr_exp();
        e_wen = 0; e_ren = 0; e_cen = 0; e_wben = 0;
        e_addr = 0; e_din = 0; e_cpc = 0; e_wbd = 0; e_wba = 0;
    endtask

    task automatic check(input string req);
        logic [164:0] act, exp;
        act = {mem_wen, mem_ren, control_en, wb_en, wb_addr, mem_addr, mem_din, control_pc, wb_data};
        exp = {e_wen, e_ren, e_cen, e_wben, e_wba, e_addr, e_din, e_cpc, e_wbd};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst=%h actual=%h expected=%h", req, inst, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] i, input logic [31:0] d, input string req);
        @(negedge clk);
        inst = i; mem_dout = d; current_pc = pc_v;
        #2 check(req);
        @(posedge clk); #1;
        if (e_wben) m[e_wba] = e_wbd;
    endtask

    task automatic do_add(input logic [4:0] rd, rs2);
        clr_exp(); e_wben = 1; e_wba = rd; e_wbd = m[rd] + m[rs2];
        issue(enc_add(rd, rs2), $urandom, "R2 add");
    endtask
    task automatic do_mv(input logic [4:0] rd, rs2);
        clr_exp(); e_wben = 1; e_wba = rd; e_wbd = m[rs2];
        issue(enc_mv(rd, rs2), $urandom, "R2 mv");
    endtask
    task automatic do_addi(input logic [4:0] rd, input logic [5:0] im);
        clr_exp(); e_wben = 1; e_wba = rd; e_wbd = m[rd] + sx6(im);
        issue(enc_ci(3'b000, rd, im, 2'b01), $urandom, "R3 addi");
    endtask
    task automatic do_li(input logic [4:0] rd, input logic [5:0] im);
        clr_exp(); e_wben = 1; e_wba = rd; e_wbd = sx6(im);
        issue(enc_ci(3'b010, rd, im, 2'b01), $urandom, "R3 li");
    endtask
    task automatic do_lui(input logic [4:0] rd, input logic [5:0] im);
        clr_exp(); e_wben = 1; e_wba = rd; e_wbd = sx6(im) << 12;
        issue(enc_ci(3'b011, rd, im, 2'b01), $urandom, "R3 lui");
    endtask
    task automatic do_slli(input logic [4:0] rd, sh);
        clr_exp(); e_wben = 1; e_wba = rd; e_wbd = m[rd] << sh;
        issue(enc_ci(3'b000, rd, {1'b0, sh}, 2'b10), $urandom, "R4 slli");
    endtask
    task automatic do_swsp(input logic [4:0] rs2, input logic [7:2] o);
        clr_exp(); e_wen = 1; e_addr = m[2] + {24'd0, o, 2'b00}; e_din = m[rs2];
        issue(enc_swsp(rs2, o), $urandom, "R5 swsp");
    endtask
    task automatic do_asp(input logic [2:0] rdp, input logic [9:2] z);
        clr_exp(); e_wben = 1; e_wba = {2'b01, rdp}; e_wbd = m[2] + {22'd0, z, 2'b00};
        issue(enc_asp(rdp, z), $urandom, "R5 addsp");
    endtask
    task automatic do_lw(input logic [2:0] rs1p, input logic [6:2] o, input logic [2:0] rdp);
        logic [31:0] d;
        d = $urandom;
        clr_exp(); e_ren = 1; e_addr = m[{2'b01, rs1p}] + {25'd0, o, 2'b00};
        e_wben = 1; e_wba = {2'b01, rdp}; e_wbd = d;
        issue(enc_mem(3'b010, rs1p, o, rdp), d, "R6 lw");
    endtask
    task automatic do_sw(input logic [2:0] rs1p, input logic [6:2] o, input logic [2:0] rsp);
        clr_exp(); e_wen = 1; e_addr = m[{2'b01, rs1p}] + {25'd0, o, 2'b00};
        e_din = m[{2'b01, rsp}];
        issue(enc_mem(3'b110, rs1p, o, rsp), $urandom, "R6 sw");
    endtask
    task automatic do_beqz(input logic [2:0] rs1p, input logic [8:1] o);
        clr_exp();
        if (m[{2'b01, rs1p}] == 0) begin
            e_cen = 1; e_cpc = pc_v + {{23{o[8]}}, o, 1'b0};
        end
        issue(enc_beqz(rs1p, o), $urandom, "R7 beqz");
    endtask
    task automatic do_j(input logic [11:1] o);
        clr_exp(); e_cen = 1; e_cpc = pc_v + {{20{o[11]}}, o, 1'b0};
        issue(enc_j(o), $urandom, "R8 j");
    endtask
    task automatic do_jr(input logic [4:0] rs1, input string req);
        clr_exp(); e_cen = 1; e_cpc = m[rs1];
        issue(enc_jr(rs1), $urandom, req);
    endtask
    task automatic do_none(input logic [15:0] i, input string req);
        clr_exp();
        issue(i, $urandom, req);
    endtask

    function automatic logic [4:0] nz5();
        logic [4:0] v;
        v = 5'($urandom);
        return (v == 0) ? 5'd1 : v;
    endfunction

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'h5eed);
        for (int i = 0; i < 32; i++) m[i] = 0;
        pc_v = 32'h100;
        // R1: enables quiet during reset even with an active instruction
        @(negedge clk); inst = enc_add(5'd5, 5'd6); #2 clr_exp(); check("R1 reset quiet");
        @(negedge clk); inst = enc_mem(3'b010, 3'd1, 5'd3, 3'd2); #2 check("R1 reset quiet load");
        @(negedge clk); inst = enc_j(11'd8); #2 check("R1 reset quiet jump");
        @(negedge clk); rst_n = 1'b1;
        // R1: registers read zero after reset
        for (int r = 1; r < 32; r += 5) do_jr(5'(r), "R1 reg zero");
        do_sw(3'd0, 5'd1, 3'd7);
        // R3 directed immediates
        do_li(5'd8, 6'h3f);
        do_li(5'd9, 6'h1f);
        do_lui(5'd10, 6'h20);
        do_lui(5'd11, 6'h01);
        do_addi(5'd8, 6'h21);
        // R4 shifts incl. boundary amounts and inst[12]=1 ignored
        do_slli(5'd9, 5'd31);
        do_slli(5'd11, 5'd0);
        do_none(enc_ci(3'b000, 5'd11, 6'h21, 2'b10), "R4 slli bit12 ignored");
        do_jr(5'd11, "R4 slli reg unchanged");
        // R2 / R12: write then immediate reuse
        do_mv(5'd12, 5'd8);
        do_add(5'd12, 5'd12);
        do_jr(5'd12, "R12 write visible next cycle");
        // R5 stack pointer base
        do_li(5'd2, 6'h10);
        do_asp(3'd3, 8'hff);
        do_swsp(5'd11, 6'h3f);
        do_none(16'h0000, "R10 zero word");
        do_jr(5'd11, "R10 zero word no write");
        // R10 / R11 no-effect patterns
        do_none(16'h8000, "R10 halt pattern");
        do_none(enc_ci(3'b000, 5'd0, 6'h05, 2'b01), "R10 nop");
        do_none(enc_ci(3'b010, 5'd0, 6'h07, 2'b01), "R11 li x0");
        do_jr(5'd1, "R11 x0 untouched via x1");
        // R7 taken and not taken
        do_li(5'd13, 6'd0);
        do_beqz(3'd5, 8'h80);
        do_li(5'd13, 6'd3);
        do_beqz(3'd5, 8'h7f);
        // R8 extreme offsets
        do_j(11'h400);
        do_j(11'h3ff);
        // Random mix
        for (int k = 0; k < 4000; k++) begin
            pc_v = $urandom & 32'hffff_fffe;
            case ($urandom % 15)
                0:  do_add(nz5(), nz5());
                1:  do_mv(nz5(), nz5());
                2:  do_addi(nz5(), 6'($urandom));
                3:  do_li(nz5(), 6'($urandom % 3 == 0 ? 0 : $urandom));
                4:  begin
                        logic [4:0] rd; logic [5:0] im;
                        rd = nz5(); if (rd == 2) rd = 3;
                        im = 6'($urandom); if (im == 0) im = 1;
                        do_lui(rd, im);
                    end
                5:  do_slli(nz5(), 5'($urandom));
                6:  do_swsp(5'($urandom), 6'($urandom));
                7:  begin
                        logic [7:0] z;
                        z = 8'($urandom); if (z == 0) z = 1;
                        do_asp(3'($urandom), z);
                    end
                8:  do_lw(3'($urandom), 5'($urandom), 3'($urandom));
                9:  do_sw(3'($urandom), 5'($urandom), 3'($urandom));
                10: do_beqz(3'($urandom), 8'($urandom));
                11: do_j(11'($urandom));
                12: do_jr(nz5(), "R9 jr");
                13: do_none(($urandom % 2) ? 16'h8000 : 16'h0001, "R10 no effect");
                default: do_none(enc_ci(3'b010, 5'd0, 6'($urandom), 2'b01), "R11 x0 write");
            endcase
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule